// File: doc/BRIEF.md
# UART Register Front End

This block is the memory-mapped register face of a small single-character UART. A 32-bit word-addressed bus reaches three registers. The first carries the character together with two handshake flags. The second holds the line configuration and a sticky error flag. The third holds the two baud-generator fields. There is no FIFO. One byte is held for transmit and one byte is held after receive.

Software sends a character by writing it with the transmit flag set. The block then gives the serializer a one-cycle start strobe and shows busy until the serializer reports that the character has gone out. A byte from the deserializer is latched and flagged as valid. Software reads it and then writes the receive flag back to release the holding byte. A byte that arrives while the previous one is still unclaimed is thrown away, and that event is recorded. The configuration fields are driven straight out to the serializer, the deserializer and the baud generator.

Read data is combinational. It is valid in the same cycle as the read request. Writes take effect at the next rising clock edge.

Top module: `uart_regif`

## Requirements
- R1: After reset, the data register reads 0x200: transmit-ready is 1, receive-valid is 0 and the character is 0. The control and clock registers read 0, and `tx_start` is low.
- R2: A read at byte offset 0x00 returns the held receive character in bits 7:0, receive-valid in bit 8 and transmit-ready in bit 9. All higher bits read 0.
- R3: A write to offset 0x00 with bit 9 set, while transmit-ready is 1, loads bits 7:0 into the transmit holding byte. From the next cycle `tx_byte` shows that value and transmit-ready reads 0.
- R4: An accepted load drives `tx_start` high for exactly one cycle, the cycle after the write. Transmit-ready stays 0 until `tx_done` is seen, and reads 1 from the following cycle. A bit-9 write while transmit-ready is 0 is ignored: there is no strobe and the byte is unchanged.
- R5: A `rx_stb` pulse while receive-valid is 0 latches `rx_char_in`. Receive-valid reads 1 from the next cycle.
- R6: A write to offset 0x00 with bit 8 set clears receive-valid. Its bits 7:0 change neither byte unless bit 9 is also set. If a new byte strobe comes in the same cycle as this acknowledge, the new byte is taken and no overrun is flagged.
- R7: A byte strobe while receive-valid is 1, with no acknowledge in that cycle, is dropped. The held byte stays as it was and control bit 9 (overrun) is set. Writing 1 to control bit 9 clears overrun. A new overrun in the same cycle as that clear leaves the flag set.
- R8: Control bits 3:2 hold the interface mode (1 = terminal side, 2 = modem side), bit 7 forces transmit-ready and bit 8 forces receive-ready. These fields read back and drive `if_mode`, `force_tx_rdy` and `force_rx_rdy`. Every other control bit except bit 9 reads 0.
- R9: Clock register (offset 0x08) bits 15:0 hold the step value and bits 27:16 the prescale value. Both read back and drive `clk_step` and `clk_prescale`. Bits 31:28 read 0.
- R10: Offsets 0x0C and 0x10, and word offsets beyond the 0x14-byte region, read 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle; 0 when not reading |
| tx_start | output | 1 | One-cycle strobe to the serializer |
| tx_byte | output | CHAR_W | Transmit holding byte |
| tx_done | input | 1 | Serializer finished the character |
| rx_stb | input | 1 | Deserializer byte-valid strobe |
| rx_char_in | input | CHAR_W | Byte from the deserializer |
| if_mode | output | 2 | Interface mode field |
| force_tx_rdy | output | 1 | Force transmit-ready to the line logic |
| force_rx_rdy | output | 1 | Force receive-ready to the line logic |
| clk_step | output | STEP_W | Baud step value |
| clk_prescale | output | PRE_W | Baud prescale value |

## Verification
The bench builds the block with its default parameters: a 5-bit byte address, 8-bit characters, a 16-bit step and a 12-bit prescale. With a 5-bit address, word indices 5 to 7 lie outside the 0x14-byte region but can still be addressed, so out-of-region accesses can be tested alongside the two holes inside the region. The 8-bit character puts the handshake flags at bits 8 and 9. These defaults give every same-cycle collision its own stimulus: acknowledge with capture, overrun with clear, and load with acknowledge.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
   localparam int BUS_W        = 32;
   // word indices of the mapped registers
   localparam int IDX_DATA     = 0;
   localparam int IDX_CTRL     = 1;
   localparam int IDX_CLKC     = 2;
   localparam int NUM_MAPPED   = 3;
   // control register field positions
   localparam int CTRL_MODE_LSB = 2;
   localparam int CTRL_MODE_W   = 2;
   localparam int CTRL_FTX      = 7;
   localparam int CTRL_FRX      = 8;
   localparam int CTRL_OVR      = 9;

   typedef struct packed {
      logic [CTRL_MODE_W-1:0] mode;
      logic                   force_tx;
      logic                   force_rx;
   } ctrl_t;
endpackage

// File: rtl/uart_regif_dec.sv
module uart_regif_dec
   import uart_regif_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int REGION_BYTES = 20,
   localparam int IDX_W       = ADDR_W - 2,
   localparam int NUM_WORDS   = 1 << IDX_W
)(
   input  logic                 sel,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_WORDS-1:0] wr_hit,
   output logic [NUM_WORDS-1:0] rd_hit
);
   logic [IDX_W-1:0] idx;
   logic             unused_lsb;

   assign idx        = addr[ADDR_W-1:2];
   assign unused_lsb = ^addr[1:0];

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      if ((i < NUM_MAPPED) && (i * 4 < REGION_BYTES)) begin : g_mapped
         assign wr_hit[i] = sel &&  wr && (idx == IDX_W'(i));
         assign rd_hit[i] = sel && !wr && (idx == IDX_W'(i));
      end else begin : g_hole
         assign wr_hit[i] = 1'b0;
         assign rd_hit[i] = 1'b0;
      end
   end
endmodule

// File: rtl/uart_regif_txhold.sv
module uart_regif_txhold #(
   parameter int CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_char,
   input  logic              done,
   output logic              ready,
   output logic              start,
   output logic [CHAR_W-1:0] char_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready  <= 1'b1;
         start  <= 1'b0;
         char_q <= '0;
      end else begin
         start <= load && ready;
         if (ready && load) begin
            char_q <= load_char;
            ready  <= 1'b0;
         end else if (!ready && done) begin
            ready  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/uart_regif_rxhold.sv
module uart_regif_rxhold #(
   parameter int CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack,
   input  logic              in_stb,
   input  logic [CHAR_W-1:0] in_char,
   output logic              valid,
   output logic [CHAR_W-1:0] char_q,
   output logic              overrun_evt
);
   logic room;

   // the acknowledge frees the slot before a same-cycle arrival is judged
   assign room        = !valid || ack;
   assign overrun_evt = in_stb && !room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         char_q <= '0;
      end else if (in_stb && room) begin
         valid  <= 1'b1;
         char_q <= in_char;
      end else if (ack) begin
         valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_regif_cfg.sv
module uart_regif_cfg
   import uart_regif_pkg::*;
#(
   parameter int STEP_W = 16,
   parameter int PRE_W  = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  ctrl_t             ctrl_in,
   input  logic              ovr_clr,
   input  logic              ovr_set,
   input  logic              clk_we,
   input  logic [STEP_W-1:0] step_in,
   input  logic [PRE_W-1:0]  pre_in,
   output ctrl_t             ctrl_q,
   output logic              ovr_q,
   output logic [STEP_W-1:0] step_q,
   output logic [PRE_W-1:0]  pre_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovr_q  <= 1'b0;
         step_q <= '0;
         pre_q  <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= ctrl_in;
         // a fresh overrun outranks a clear in the same cycle
         if (ovr_set)      ovr_q <= 1'b1;
         else if (ovr_clr) ovr_q <= 1'b0;
         if (clk_we) begin
            step_q <= step_in;
            pre_q  <= pre_in;
         end
      end
   end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
   import uart_regif_pkg::*;
#(
   parameter int ADDR_W       = 5,
   parameter int CHAR_W       = 8,
   parameter int STEP_W       = 16,
   parameter int PRE_W        = 12,
   parameter int REGION_BYTES = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_start,
   output logic [CHAR_W-1:0] tx_byte,
   input  logic              tx_done,
   input  logic              rx_stb,
   input  logic [CHAR_W-1:0] rx_char_in,
   output logic [1:0]        if_mode,
   output logic              force_tx_rdy,
   output logic              force_rx_rdy,
   output logic [STEP_W-1:0] clk_step,
   output logic [PRE_W-1:0]  clk_prescale
);
   localparam int IDX_W     = ADDR_W - 2;
   localparam int NUM_WORDS = 1 << IDX_W;
   localparam int RXV_BIT   = CHAR_W;
   localparam int TXR_BIT   = CHAR_W + 1;
   localparam int CLK_USED  = STEP_W + PRE_W;

   // elaboration-time parameter checks
   if (ADDR_W < 4) begin : g_bad_addr
      $error("uart_regif: ADDR_W must cover three register words");
   end
   if (TXR_BIT >= BUS_W) begin : g_bad_char
      $error("uart_regif: CHAR_W leaves no room for handshake flags");
   end
   if (CLK_USED > BUS_W) begin : g_bad_clk
      $error("uart_regif: step and prescale exceed the bus width");
   end
   if ((REGION_BYTES < 4 * NUM_MAPPED) || (REGION_BYTES > (1 << ADDR_W))) begin : g_bad_region
      $error("uart_regif: REGION_BYTES out of range");
   end

   logic [NUM_WORDS-1:0] wr_hit, rd_hit;
   logic                 tx_rdy_q, rx_vld_q, ovr_q, ovr_evt;
   logic [CHAR_W-1:0]    rx_char_q;
   ctrl_t                ctrl_in, ctrl_q;
   logic [BUS_W-1:0]     rd_words [NUM_WORDS];
   logic [BUS_W-1:0]     ctrl_word;
   logic                 unused_hit;

   uart_regif_dec #(
      .ADDR_W       (ADDR_W),
      .REGION_BYTES (REGION_BYTES)
   ) u_dec (
      .sel    (bus_sel),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wr_hit (wr_hit),
      .rd_hit (rd_hit)
   );

   assign unused_hit = ^wr_hit[NUM_WORDS-1:NUM_MAPPED] ^ ^rd_hit[NUM_WORDS-1:NUM_MAPPED];

   uart_regif_txhold #(.CHAR_W(CHAR_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_hit[IDX_DATA] && bus_wdata[TXR_BIT]),
      .load_char (bus_wdata[CHAR_W-1:0]),
      .done      (tx_done),
      .ready     (tx_rdy_q),
      .start     (tx_start),
      .char_q    (tx_byte)
   );

   uart_regif_rxhold #(.CHAR_W(CHAR_W)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack         (wr_hit[IDX_DATA] && bus_wdata[RXV_BIT]),
      .in_stb      (rx_stb),
      .in_char     (rx_char_in),
      .valid       (rx_vld_q),
      .char_q      (rx_char_q),
      .overrun_evt (ovr_evt)
   );

   assign ctrl_in.mode     = bus_wdata[CTRL_MODE_LSB +: CTRL_MODE_W];
   assign ctrl_in.force_tx = bus_wdata[CTRL_FTX];
   assign ctrl_in.force_rx = bus_wdata[CTRL_FRX];

   uart_regif_cfg #(.STEP_W(STEP_W), .PRE_W(PRE_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (wr_hit[IDX_CTRL]),
      .ctrl_in (ctrl_in),
      .ovr_clr (wr_hit[IDX_CTRL] && bus_wdata[CTRL_OVR]),
      .ovr_set (ovr_evt),
      .clk_we  (wr_hit[IDX_CLKC]),
      .step_in (bus_wdata[STEP_W-1:0]),
      .pre_in  (bus_wdata[STEP_W +: PRE_W]),
      .ctrl_q  (ctrl_q),
      .ovr_q   (ovr_q),
      .step_q  (clk_step),
      .pre_q   (clk_prescale)
   );

   assign if_mode      = ctrl_q.mode;
   assign force_tx_rdy = ctrl_q.force_tx;
   assign force_rx_rdy = ctrl_q.force_rx;

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CTRL_MODE_LSB +: CTRL_MODE_W] = ctrl_q.mode;
      ctrl_word[CTRL_FTX] = ctrl_q.force_tx;
      ctrl_word[CTRL_FRX] = ctrl_q.force_rx;
      ctrl_word[CTRL_OVR] = ovr_q;
   end

   if (CLK_USED < BUS_W) begin : g_wdata_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata[BUS_W-1:CLK_USED];
   end

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_rdw
      if (i == IDX_DATA) begin : g_data
         assign rd_words[i] = BUS_W'({tx_rdy_q, rx_vld_q, rx_char_q});
      end else if (i == IDX_CTRL) begin : g_ctrl
         assign rd_words[i] = ctrl_word;
      end else if (i == IDX_CLKC) begin : g_clkc
         assign rd_words[i] = BUS_W'({clk_prescale, clk_step});
      end else begin : g_zero
         assign rd_words[i] = '0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (rd_hit[i]) bus_rdata = bus_rdata | rd_words[i];
      end
   end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
   parameter int IDX_W  = 3,
   parameter int CHAR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [IDX_W-1:0]  word_idx,
   input logic              flag_tx,
   input logic              flag_rx,
   input logic [31:0]       bus_rdata,
   input logic              tx_start,
   input logic              tx_done,
   input logic              rx_stb,
   input logic              tx_rdy_q,
   input logic              rx_vld_q,
   input logic [CHAR_W-1:0] rx_char_q,
   input logic              ovr_q
);
   logic data_wr, load, ack;
   assign data_wr = bus_sel && bus_wr && (word_idx == '0);
   assign load    = data_wr && flag_tx;
   assign ack     = data_wr && flag_rx;

   a_r3_load_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (load && tx_rdy_q) |=> (tx_start && !tx_rdy_q));

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rdy_q && !tx_done) |=> !tx_rdy_q);

   a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_rdy_q && tx_done) |=> tx_rdy_q);

   a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && !rx_vld_q) |=> rx_vld_q);

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !rx_stb) |=> !rx_vld_q);

   a_r7_overrun_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_stb && rx_vld_q && !ack) |=> (ovr_q && $stable(rx_char_q)));

   a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (word_idx >= IDX_W'(3))) |-> (bus_rdata == '0));
endmodule

bind uart_regif uart_regif_chk #(.IDX_W(ADDR_W - 2), .CHAR_W(CHAR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .word_idx  (bus_addr[ADDR_W-1:2]),
   .flag_tx   (bus_wdata[CHAR_W+1]),
   .flag_rx   (bus_wdata[CHAR_W]),
   .bus_rdata (bus_rdata),
   .tx_start  (tx_start),
   .tx_done   (tx_done),
   .rx_stb    (rx_stb),
   .tx_rdy_q  (tx_rdy_q),
   .rx_vld_q  (rx_vld_q),
   .rx_char_q (rx_char_q),
   .ovr_q     (ovr_q)
);

// File: tb/uart_regif_tb.sv
module uart_regif_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_start, tx_done = 1'b0, rx_stb = 1'b0;
   logic [7:0]  tx_byte, rx_char_in = '0;
   logic [1:0]  if_mode;
   logic        force_tx_rdy, force_rx_rdy;
   logic [15:0] clk_step;
   logic [11:0] clk_prescale;

   int n_chk = 0, n_bad = 0;
   bit fin = 0, run = 0;

   always #5 clk = ~clk;

   uart_regif u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_start(tx_start), .tx_byte(tx_byte), .tx_done(tx_done),
      .rx_stb(rx_stb), .rx_char_in(rx_char_in), .if_mode(if_mode),
      .force_tx_rdy(force_tx_rdy), .force_rx_rdy(force_rx_rdy),
      .clk_step(clk_step), .clk_prescale(clk_prescale)
   );

   // reference model state
   bit         m_txr, m_rxv, m_ovr, m_start, m_ftx, m_frx;
   logic [7:0] m_txb, m_rxb;
   logic [1:0] m_mode;
   logic [15:0] m_step;
   logic [11:0] m_pre;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   always @(posedge clk) begin : upd
      int widx;
      bit wrq, ack;
      if (!rst_n) begin
         m_txr = 1; m_rxv = 0; m_ovr = 0; m_start = 0; m_ftx = 0; m_frx = 0;
         m_txb = 0; m_rxb = 0; m_mode = 0; m_step = 0; m_pre = 0;
      end else begin
         wrq  = bus_sel && bus_wr;
         widx = int'(bus_addr >> 2);
         m_start = 0;
         if (wrq && widx == 0 && bus_wdata[9] && m_txr) begin
            m_txb = bus_wdata[7:0]; m_txr = 0; m_start = 1;
         end else if (!m_txr && tx_done) begin
            m_txr = 1;
         end
         ack = wrq && widx == 0 && bus_wdata[8];
         if (ack) m_rxv = 0;
         if (wrq && widx == 1 && bus_wdata[9]) m_ovr = 0;
         if (rx_stb) begin
            if (m_rxv) m_ovr = 1;
            else begin m_rxb = rx_char_in; m_rxv = 1; end
         end
         if (wrq && widx == 1) begin
            m_mode = bus_wdata[3:2]; m_ftx = bus_wdata[7]; m_frx = bus_wdata[8];
         end
         if (wrq && widx == 2) begin
            m_step = bus_wdata[15:0]; m_pre = bus_wdata[27:16];
         end
      end
   end

   function automatic logic [31:0] mread(input logic [4:0] a);
      case (a >> 2)
         0: mread = {22'd0, m_txr, m_rxv, m_rxb};
         1: mread = {22'd0, m_ovr, m_frx, m_ftx, 3'd0, m_mode, 2'd0};
         2: mread = {4'd0, m_pre, m_step};
         default: mread = 32'd0;
      endcase
   endfunction

   // outputs compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && run) begin
         chk(tx_start === m_start, "R4 tx_start strobe", 32'(tx_start), 32'(m_start));
         chk(tx_byte === m_txb, "R3 tx_byte", 32'(tx_byte), 32'(m_txb));
         chk({if_mode, force_tx_rdy, force_rx_rdy} === {m_mode, m_ftx, m_frx},
             "R8 control outputs", 32'({if_mode, force_tx_rdy, force_rx_rdy}),
             32'({m_mode, m_ftx, m_frx}));
         chk({clk_prescale, clk_step} === {m_pre, m_step}, "R9 clock outputs",
             32'({clk_prescale, clk_step}), 32'({m_pre, m_step}));
      end
   end

   task automatic op(input bit s, input bit w, input logic [4:0] a, input logic [31:0] d,
                     input bit dn, input bit rs, input logic [7:0] rb, input string tag);
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      tx_done = dn; rx_stb = rs; rx_char_in = rb;
      #1;
      if (s && !w) chk(bus_rdata === mread(a), tag, bus_rdata, mread(a));
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      op(1, 1, a, d, 0, 0, 8'h00, tag);
   endtask

   task automatic idle();
      op(0, 0, 5'd0, 32'd0, 0, 0, 8'h00, "idle");
   endtask

   // read, compare with the model, and with a literal from the requirement
   task automatic rdx(input logic [4:0] a, input logic [31:0] exp, input string tag);
      op(1, 0, a, 32'd0, 0, 0, 8'h00, tag);
      chk(bus_rdata === exp, tag, bus_rdata, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      run = 1;
      // R1 / R2 reset state
      rdx(5'h00, 32'h0000_0200, "R1 R2 data after reset");
      rdx(5'h04, 32'h0, "R1 control after reset");
      rdx(5'h08, 32'h0, "R1 clock after reset");
      // R3 load and R4 strobe
      wr(5'h00, 32'h0000_0241, "R3 load");
      idle();
      rdx(5'h00, 32'h0000_0000, "R3 ready cleared");
      wr(5'h00, 32'h0000_0255, "R4 load while busy");
      rdx(5'h00, 32'h0000_0000, "R4 busy ignores load");
      chk(tx_byte === 8'h41, "R4 byte kept while busy", 32'(tx_byte), 32'h41);
      op(0, 0, 5'd0, 32'd0, 1, 0, 8'h00, "R4 done");
      rdx(5'h00, 32'h0000_0200, "R4 ready after done");
      // R5 capture
      op(0, 0, 5'd0, 32'd0, 0, 1, 8'h5A, "R5 byte in");
      rdx(5'h00, 32'h0000_035A, "R5 valid set");
      // R7 overrun
      op(0, 0, 5'd0, 32'd0, 0, 1, 8'hC3, "R7 second byte");
      rdx(5'h00, 32'h0000_035A, "R7 byte dropped");
      rdx(5'h04, 32'h0000_0200, "R7 overrun set");
      // R6 acknowledge ignores char bits
      wr(5'h00, 32'h0000_01FF, "R6 ack");
      rdx(5'h00, 32'h0000_025A, "R6 valid cleared");
      chk(tx_byte === 8'h41, "R6 ack leaves tx byte", 32'(tx_byte), 32'h41);
      wr(5'h04, 32'h0000_0200, "R7 clear");
      rdx(5'h04, 32'h0, "R7 overrun cleared");
      // R7 set beats clear
      op(0, 0, 5'd0, 32'd0, 0, 1, 8'h11, "R7 fill");
      op(1, 1, 5'h04, 32'h0000_0200, 0, 1, 8'h22, "R7 set and clear");
      rdx(5'h04, 32'h0000_0200, "R7 set wins");
      rdx(5'h00, 32'h0000_0311, "R7 held byte kept");
      wr(5'h04, 32'h0000_0200, "R7 clear again");
      // R6 ack with same-cycle arrival
      op(1, 1, 5'h00, 32'h0000_0100, 0, 1, 8'h44, "R6 ack plus byte");
      rdx(5'h00, 32'h0000_0344, "R6 new byte taken");
      rdx(5'h04, 32'h0, "R6 no overrun");
      // R8 control
      wr(5'h04, 32'hFFFF_FFFF, "R8 all ones");
      rdx(5'h04, 32'h0000_018C, "R8 readback all ones");
      wr(5'h04, 32'h0000_0108, "R8 modem side");
      rdx(5'h04, 32'h0000_0108, "R8 readback modem side");
      wr(5'h04, 32'h0000_0084, "R8 terminal side");
      rdx(5'h04, 32'h0000_0084, "R8 readback terminal side");
      // R9 clock
      wr(5'h08, 32'hFFFF_FFFF, "R9 all ones");
      rdx(5'h08, 32'h0FFF_FFFF, "R9 top bits zero");
      wr(5'h08, 32'h0123_4567, "R9 pattern");
      rdx(5'h08, 32'h0123_4567, "R9 readback");
      // R10 holes and out-of-region words
      for (int i = 3; i < 8; i++) wr(5'(i * 4), 32'hFFFF_FFFF, "R10 hole write");
      for (int i = 3; i < 8; i++) rdx(5'(i * 4), 32'h0, "R10 hole read");
      rdx(5'h04, 32'h0000_0084, "R10 control untouched");
      rdx(5'h08, 32'h0123_4567, "R10 clock untouched");
      rdx(5'h00, 32'h0000_0344, "R10 data untouched");
      // R3 and R6 in one write
      wr(5'h00, 32'h0000_037E, "R3 R6 load plus ack");
      rdx(5'h00, 32'h0000_0044, "R3 R6 both applied");
      op(0, 0, 5'd0, 32'd0, 1, 0, 8'h00, "R4 done");
      rdx(5'h00, 32'h0000_0244, "R4 ready again");
      idle();
      idle();
      fin = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule